// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Aggregator

This block gathers the interrupt events of a PCIe root port and turns them into one interrupt request for the host processor. It takes two kinds of event. The first kind is four legacy level-sensitive lines, one for each of the four legacy interrupt pins. The second kind is message-signalled interrupt (MSI) writes. An MSI write is modelled as a one-cycle strobe that carries a vector number in the range 0 to 31. Legacy lines are latched into a local status word. An MSI event sets one bit of a 32-bit vector status word. That vector word is then summarised into a single bit of the local status word.

Software uses a 32-bit register port to reach four registers: the local enable mask, the local status word, a read-only MSI target address and the MSI vector status word. The two status registers are cleared by writing ones. The legacy bits follow level semantics: while the line is still high when software acknowledges, the bit sets again. MSI bits follow edge semantics: a bit stays set until software clears it. The interrupt output is high whenever any local status bit is set and also enabled in the mask.

Top module: `pcie_irq_agg`

## Requirements
- R1: After reset the mask register, the local status word and the MSI vector status word all read zero, and `irq_o` is low.
- R2: Offset 0x180 is the mask register. It is read/write. Bits 24..27 enable legacy pins A..D, and bit 28 enables the MSI summary. All other bits read as zero.
- R3: When legacy line n (0..3) is high at a clock edge, bit 24+n of the local status word (offset 0x184) is set after that edge. The bit stays set after the line falls.
- R4: Writing a one to bit 24+n of offset 0x184 clears that bit only if legacy line n is low in the same cycle. If the line is still high, the bit stays set. Zero bits in the write leave the status unchanged.
- R5: An MSI strobe carrying vector v sets bit v of the MSI vector status word (offset 0x194) after the edge. The bit stays set until a one is written to bit v of 0x194. Zero bits in the write leave it unchanged.
- R6: When an MSI strobe for vector v and a write-one-to-clear of bit v of 0x194 fall in the same cycle, the bit ends up set.
- R7: Bit 28 of the local status word is set after any edge at which the MSI vector status word is non-zero. A write of one to bit 28 clears it only if the vector status word is zero in that cycle.
- R8: `irq_o` is high exactly when some bit of the local status word is set and the same bit of the mask register is set.
- R9: Offset 0x190 reads the constant given by parameter `MSI_ADDR`. Writes to it have no effect.
- R10: A read of any other offset returns zero. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset, used for both read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr`, combinational |
| intx_lvl | input | 4 | Legacy interrupt lines A..D, active high, level-sensitive |
| msi_valid | input | 1 | One-cycle MSI write strobe |
| msi_data | input | VEC_W | Vector number carried by the MSI write |
| irq_o | output | 1 | Combined interrupt request to the host |

## Verification
The bench runs directed sequences and then a long random phase. In the random phase, legacy levels, MSI strobes and register writes overlap freely, and a behavioural model predicts `irq_o` and the read data on every cycle. Two kinds of acknowledge are set against each other: acknowledging a line that is still high and acknowledging one that has dropped. This separates level semantics from a plain sticky latch. An MSI strobe that hits the vector being cleared in the same cycle checks that the set wins. Clearing the summary bit before and after the vector word is empty shows that the summary is re-evaluated from the vector word and is not a simple latch. Runs with the mask at zero, partially set and fully set show that the output depends on gating and not on status alone.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;
  // register byte offsets (software decodes these)
  localparam logic [11:0] OFS_MASK    = 12'h180;
  localparam logic [11:0] OFS_LSTAT   = 12'h184;
  localparam logic [11:0] OFS_MSIADDR = 12'h190;
  localparam logic [11:0] OFS_MSISTAT = 12'h194;

  // local status / mask bit map
  localparam int NUM_INTX = 4;
  localparam int LCL_LSB  = 24;            // first legacy pin bit
  localparam int LCL_W    = NUM_INTX + 1;  // legacy pins plus MSI summary
endpackage

// File: rtl/pcie_irq_lcl_status.sv
// Local status word: legacy level bits plus the MSI summary bit.
module pcie_irq_lcl_status
  import pcie_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INTX-1:0] intx_lvl,
  input  logic                msi_any,
  input  logic                clr_en,
  input  logic [LCL_W-1:0]    clr_bits,
  output logic [LCL_W-1:0]    sts_q
);
  logic [LCL_W-1:0] set_vec;
  logic [LCL_W-1:0] clr_vec;
  logic [LCL_W-1:0] sts_d;
  logic             sts_en;

  assign set_vec = {msi_any, intx_lvl};
  assign clr_vec = clr_en ? clr_bits : '0;

  // set has priority over a same-cycle clear
  always_comb begin
    sts_d  = (sts_q & ~clr_vec) | set_vec;
    sts_en = clr_en | (|(set_vec & ~sts_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end
endmodule

// File: rtl/pcie_irq_msi_status.sv
// Edge-captured MSI vector status, one sticky bit per vector.
module pcie_irq_msi_status #(
  parameter int NUM_VEC = 32,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [VEC_W-1:0]   ev_vec,
  input  logic               clr_en,
  input  logic [NUM_VEC-1:0] clr_bits,
  output logic [NUM_VEC-1:0] sts_q,
  output logic               any_o
);
  logic [NUM_VEC-1:0] hit;
  logic [NUM_VEC-1:0] sts_d;
  logic [NUM_VEC-1:0] sts_en;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign hit[v] = ev_valid && (ev_vec == VEC_W'(v));

    always_comb begin
      sts_en[v] = hit[v] | (clr_en & clr_bits[v]);
      sts_d[v]  = hit[v];   // a strobe wins over a same-cycle clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts_q[v] <= 1'b0;
      end else if (sts_en[v]) begin
        sts_q[v] <= sts_d[v];
      end
    end
  end

  assign any_o = |sts_q;
endmodule

// File: rtl/pcie_irq_regif.sv
// Register decode: write strobes out, read mux in.
module pcie_irq_regif
  import pcie_irq_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 32,
  parameter int                NUM_VEC  = 32,
  parameter logic [DATA_W-1:0] MSI_ADDR = '0
) (
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [LCL_W-1:0]   mask_q,
  input  logic [LCL_W-1:0]   lsts_q,
  input  logic [NUM_VEC-1:0] msi_sts_q,
  output logic               mask_we,
  output logic               lsts_clr,
  output logic               msi_clr,
  output logic [LCL_W-1:0]   lcl_wbits,
  output logic [NUM_VEC-1:0] msi_wbits,
  output logic [DATA_W-1:0]  reg_rdata
);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_LSTAT   = ADDR_W'(OFS_LSTAT);
  localparam logic [ADDR_W-1:0] A_MSIADDR = ADDR_W'(OFS_MSIADDR);
  localparam logic [ADDR_W-1:0] A_MSISTAT = ADDR_W'(OFS_MSISTAT);

  assign mask_we   = reg_we && (reg_addr == A_MASK);
  assign lsts_clr  = reg_we && (reg_addr == A_LSTAT);
  assign msi_clr   = reg_we && (reg_addr == A_MSISTAT);
  assign lcl_wbits = reg_wdata[LCL_LSB +: LCL_W];
  assign msi_wbits = reg_wdata[NUM_VEC-1:0];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_MASK:    reg_rdata[LCL_LSB +: LCL_W] = mask_q;
      A_LSTAT:   reg_rdata[LCL_LSB +: LCL_W] = lsts_q;
      A_MSIADDR: reg_rdata = MSI_ADDR;
      A_MSISTAT: reg_rdata[NUM_VEC-1:0] = msi_sts_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pcie_irq_agg.sv
// Top: mask register, status blocks and combined request.
module pcie_irq_agg
  import pcie_irq_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 32,
  parameter int                NUM_VEC  = 32,
  parameter logic [DATA_W-1:0] MSI_ADDR = 32'hFEE0_1000,
  localparam int               VEC_W    = $clog2(NUM_VEC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_INTX-1:0] intx_lvl,
  input  logic                msi_valid,
  input  logic [VEC_W-1:0]    msi_data,
  output logic                irq_o
);
  logic [LCL_W-1:0]   mask_q;
  logic [LCL_W-1:0]   mask_d;
  logic               mask_we;
  logic [LCL_W-1:0]   lsts_q;
  logic               lsts_clr;
  logic [LCL_W-1:0]   lcl_wbits;
  logic [NUM_VEC-1:0] msi_sts_q;
  logic               msi_clr;
  logic [NUM_VEC-1:0] msi_wbits;
  logic               msi_any;

  pcie_irq_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC), .MSI_ADDR(MSI_ADDR)
  ) u_regif (
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mask_q    (mask_q),
    .lsts_q    (lsts_q),
    .msi_sts_q (msi_sts_q),
    .mask_we   (mask_we),
    .lsts_clr  (lsts_clr),
    .msi_clr   (msi_clr),
    .lcl_wbits (lcl_wbits),
    .msi_wbits (msi_wbits),
    .reg_rdata (reg_rdata)
  );

  pcie_irq_msi_status #(.NUM_VEC(NUM_VEC)) u_msi (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (msi_valid),
    .ev_vec   (msi_data),
    .clr_en   (msi_clr),
    .clr_bits (msi_wbits),
    .sts_q    (msi_sts_q),
    .any_o    (msi_any)
  );

  pcie_irq_lcl_status u_lcl (
    .clk      (clk),
    .rst_n    (rst_n),
    .intx_lvl (intx_lvl),
    .msi_any  (msi_any),
    .clr_en   (lsts_clr),
    .clr_bits (lcl_wbits),
    .sts_q    (lsts_q)
  );

  // mask register
  always_comb begin
    mask_d = lcl_wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  assign irq_o = |(lsts_q & mask_q);
endmodule

// File: rtl/pcie_irq_agg_chk.sv
module pcie_irq_agg_chk
  import pcie_irq_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 32,
  parameter int                NUM_VEC  = 32,
  parameter logic [DATA_W-1:0] MSI_ADDR = '0,
  localparam int               VEC_W    = $clog2(NUM_VEC)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [NUM_INTX-1:0] intx_lvl,
  input logic                msi_valid,
  input logic [VEC_W-1:0]    msi_data,
  input logic [LCL_W-1:0]    mask_q,
  input logic [LCL_W-1:0]    lsts_q,
  input logic [NUM_VEC-1:0]  msi_sts_q,
  input logic                irq_o
);
  localparam logic [ADDR_W-1:0] A_MSIADDR = ADDR_W'(OFS_MSIADDR);
  localparam logic [ADDR_W-1:0] A_MSISTAT = ADDR_W'(OFS_MSISTAT);

  // R1
  rst_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '0 && lsts_q == '0 && msi_sts_q == '0 && !irq_o));

  // R3
  intx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|intx_lvl) |=> ((lsts_q[NUM_INTX-1:0] & $past(intx_lvl)) == $past(intx_lvl)));

  // R5
  msi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid |=> msi_sts_q[$past(msi_data)]);

  // R5
  msi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_MSISTAT) |=> ((msi_sts_q & $past(msi_sts_q)) == $past(msi_sts_q)));

  // R7
  msi_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|msi_sts_q) |=> lsts_q[NUM_INTX]);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  // R9
  msi_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_MSIADDR) |-> (reg_rdata == MSI_ADDR));
endmodule

bind pcie_irq_agg pcie_irq_agg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC), .MSI_ADDR(MSI_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .intx_lvl  (intx_lvl),
  .msi_valid (msi_valid),
  .msi_data  (msi_data),
  .mask_q    (mask_q),
  .lsts_q    (lsts_q),
  .msi_sts_q (msi_sts_q),
  .irq_o     (irq_o)
);

// File: tb/pcie_irq_agg_tb.sv
`timescale 1ns/1ps
module pcie_irq_agg_tb;
  localparam logic [31:0] MADDR = 32'hFEED_0040;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  intx_lvl;
  logic        msi_valid;
  logic [4:0]  msi_data;
  logic        irq_o;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // behavioural reference state (32-bit words as software sees them)
  logic [31:0] m_mask, m_lsts, m_msi;

  always #2 clk = ~clk;

  pcie_irq_agg #(.MSI_ADDR(MADDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .intx_lvl(intx_lvl),
    .msi_valid(msi_valid), .msi_data(msi_data), .irq_o(irq_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask <= 0; m_lsts <= 0; m_msi <= 0;
    end else begin
      logic [31:0] nl, nm;
      nl = m_lsts; nm = m_msi;
      if (reg_we && reg_addr == 12'h184) nl = nl & ~(reg_wdata & 32'h1F00_0000);
      if (reg_we && reg_addr == 12'h194) nm = nm & ~reg_wdata;
      for (int k = 0; k < 4; k++) if (intx_lvl[k]) nl[24+k] = 1'b1;
      if (m_msi != 0) nl[28] = 1'b1;
      if (msi_valid) nm[msi_data] = 1'b1;
      if (reg_we && reg_addr == 12'h180) m_mask <= reg_wdata & 32'h1F00_0000;
      m_lsts <= nl;
      m_msi  <= nm;
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h180: return m_mask;
      12'h184: return m_lsts;
      12'h190: return MADDR;
      12'h194: return m_msi;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // advance one cycle and compare against the model
  task automatic tick();
    @(negedge clk);
    chk("R8", {cur_req, " irq"}, {31'b0, irq_o}, {31'b0, (m_lsts & m_mask) != 0});
    chk(cur_req, "rdata", reg_rdata, m_read(reg_addr));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    reg_addr = a;
    tick();
  endtask

  task automatic msi(input logic [4:0] v);
    msi_valid = 1; msi_data = v;
    tick();
    msi_valid = 0;
  endtask

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 12'h180; reg_wdata = 0;
    intx_lvl = 0; msi_valid = 0; msi_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    cur_req = "R1";
    rd(12'h180); chk("R1", "mask", reg_rdata, 32'h0);
    rd(12'h184); chk("R1", "lstat", reg_rdata, 32'h0);
    rd(12'h194); chk("R1", "msistat", reg_rdata, 32'h0);
    chk("R1", "irq", {31'b0, irq_o}, 32'h0);

    // R2 mask register
    cur_req = "R2";
    wr(12'h180, 32'hFFFF_FFFF); rd(12'h180);
    chk("R2", "mask implemented bits", reg_rdata, 32'h1F00_0000);
    wr(12'h180, 32'h0);

    // R9 MSI address constant
    cur_req = "R9";
    rd(12'h190); chk("R9", "msi addr", reg_rdata, MADDR);
    wr(12'h190, 32'h1234_5678); rd(12'h190);
    chk("R9", "msi addr after write", reg_rdata, MADDR);

    // R3 legacy set and stickiness
    cur_req = "R3";
    intx_lvl = 4'b0010; tick(); intx_lvl = 0;
    rd(12'h184); chk("R3", "pin B set", reg_rdata, 32'h0200_0000);
    rd(12'h184); chk("R3", "pin B sticky", reg_rdata, 32'h0200_0000);

    // R4 level acknowledge
    cur_req = "R4";
    intx_lvl = 4'b0100; tick();
    wr(12'h184, 32'h0400_0000); rd(12'h184);
    chk("R4", "ack with line high keeps bit", reg_rdata & 32'h0400_0000, 32'h0400_0000);
    intx_lvl = 0;
    wr(12'h184, 32'h0000_0000); rd(12'h184);
    chk("R4", "zero write no effect", reg_rdata, 32'h0600_0000);
    wr(12'h184, 32'h0600_0000); rd(12'h184);
    chk("R4", "ack with line low clears", reg_rdata, 32'h0);

    // R5 MSI capture
    cur_req = "R5";
    msi(5'd0); msi(5'd31); msi(5'd7);
    rd(12'h194); chk("R5", "vectors 0,7,31", reg_rdata, 32'h8000_0081);
    wr(12'h194, 32'h0000_0080); rd(12'h194);
    chk("R5", "clear vector 7", reg_rdata, 32'h8000_0001);

    // R6 same-cycle set and clear
    cur_req = "R6";
    msi_valid = 1; msi_data = 5'd0;
    wr(12'h194, 32'h0000_0001);
    msi_valid = 0;
    rd(12'h194); chk("R6", "set wins", reg_rdata, 32'h8000_0001);

    // R7 summary bit
    cur_req = "R7";
    rd(12'h184); chk("R7", "summary set", reg_rdata, 32'h1000_0000);
    wr(12'h184, 32'h1000_0000); rd(12'h184);
    chk("R7", "summary held while vectors pending", reg_rdata, 32'h1000_0000);

    // R8 gating
    cur_req = "R8";
    chk("R8", "masked irq", {31'b0, irq_o}, 32'h0);
    wr(12'h180, 32'h0100_0000); rd(12'h180);
    chk("R8", "other bit enabled irq", {31'b0, irq_o}, 32'h0);
    wr(12'h180, 32'h1000_0000); rd(12'h180);
    chk("R8", "summary enabled irq", {31'b0, irq_o}, 32'h1);

    cur_req = "R7";
    wr(12'h194, 32'hFFFF_FFFF);
    wr(12'h184, 32'hFFFF_FFFF); rd(12'h184);
    chk("R7", "summary cleared once vectors empty", reg_rdata, 32'h0);
    chk("R8", "irq drops", {31'b0, irq_o}, 32'h0);

    // R10 unmapped
    cur_req = "R10";
    wr(12'h188, 32'hFFFF_FFFF); rd(12'h188);
    chk("R10", "unmapped read", reg_rdata, 32'h0);
    rd(12'h180); chk("R10", "mask untouched", reg_rdata, 32'h1000_0000);

    // random overlap, compared every cycle (R3 R4 R5 R6 R7 R8)
    cur_req = "R3 R4 R5 R6 R7 random";
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] sel;
      intx_lvl  = ($urandom % 4 == 0) ? 4'($urandom) : intx_lvl;
      msi_valid = ($urandom % 3 == 0);
      msi_data  = 5'($urandom);
      sel       = 3'($urandom);
      reg_we    = ($urandom % 4 == 0);
      case (sel)
        3'd0: reg_addr = 12'h180;
        3'd1, 3'd2: reg_addr = 12'h184;
        3'd3: reg_addr = 12'h190;
        3'd4, 3'd5: reg_addr = 12'h194;
        default: reg_addr = 12'h1A0;
      endcase
      reg_wdata = $urandom;
      tick();
    end
    reg_we = 0; msi_valid = 0; intx_lvl = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule